// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block is a bus master for an external bus on which the low address byte and the data byte share the same eight wires. It runs on a clock eight times faster than the bus cycle, so every bus cycle is made of eight equal phases. From those phases it generates the bus clock E and the address strobe AS. It drives the high address byte, the shared low-address/data byte and the read/write line. It also raises an output enable for the shared byte whenever the master is driving it.

On the internal side, a requester raises `req` together with the address, the direction and the write data. The block takes the request at the end of phase 0 and runs one read or write cycle. When the cycle ends, it pulses `ack` for one clock, during the phase 0 that follows. For a read, `rd_data` is valid during that pulse. While no request is pending, the block runs idle cycles: E and AS keep toggling, the read/write line shows read, and the shared byte is not driven.

The sequencer is built from two state machines. The first is the phase machine, which steps through eight states: PH0_HOLD, PH1_AS_RISE, PH2_AS_HIGH, PH3_ALO_HOLD, PH4_E_RISE, PH5_DATA, PH6_DATA and PH7_SAMPLE. It moves PH0→PH1→…→PH7→PH0 with no other transition. The second is the cycle machine, which has three states: CY_IDLE, CY_READ and CY_WRITE. Its transitions are START_RD (CY_IDLE→CY_READ), START_WR (CY_IDLE→CY_WRITE) and FINISH (CY_READ or CY_WRITE→CY_IDLE). All three can fire only at the end of PH0_HOLD. In every other phase the cycle machine stays where it is.

Top module: `mxbus_seq`

## Requirements
- R1: While `rst` is high, and in the first phase after it, `bus_e`=0, `bus_as`=0, `bus_rw`=1, `bus_ad_oe`=0 and `ack`=0. The first clock after reset is phase 0.
- R2: `bus_e` is low in phases 0–3 and high in phases 4–7, repeating every 8 clocks whether or not a request is pending.
- R3: `bus_as` is high only in phases 1 and 2. It rises one clock after E falls and falls one clock before E rises, so it is never high while E is high.
- R4: A request is taken only if `req` is high in the clock that ends phase 0 and `ack` is low in that clock. A `req` that is high only in other phases starts nothing: the next cycle stays idle with `bus_rw`=1, `bus_ad_oe`=0 and no `ack`.
- R5: During a read or write, `bus_ahi` equals address bits [15:8] from phase 1 through the following phase 0. `bus_ad_out` equals address bits [7:0], with `bus_ad_oe`=1, in phases 1–3, and for a write also in phase 4. The request inputs may change after phase 0 without effect.
- R6: During a write, `bus_rw`=0 from phase 1 through the following phase 0. `bus_ad_out` equals the write data, with `bus_ad_oe`=1, in phases 5–7 and the following phase 0.
- R7: During a read, `bus_rw`=1 and `bus_ad_oe`=0 from phase 4 through the following phase 0. `bus_ad_in` is captured at the clock edge that ends phase 7, where E falls.
- R8: `ack` is high for exactly one clock, in the phase 0 after each read or write cycle, and never after an idle cycle. For a read, `rd_data` holds the captured byte while `ack` is high.
- R9: If `req` is held high continuously, the block runs the operation, then one idle cycle, because the ack phase does not accept a request. It starts the next operation at the following phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, eight per bus cycle |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request for a bus cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Bus address |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Captured read data |
| bus_e | output | 1 | Bus clock E |
| bus_as | output | 1 | Address strobe |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_ahi | output | 8 | High address byte |
| bus_ad_out | output | 8 | Shared low-address/data byte, driven value |
| bus_ad_in | input | 8 | Shared low-address/data byte, received value |
| bus_ad_oe | output | 1 | Output enable for the shared byte |

## Verification
Writes and reads are tried with address bytes that differ in the high and low halves and with data patterns such as 3C, C3, FF and 00. These patterns separate a swapped or stale byte on the shared wires from a correct one. The bus model drives the read byte only in phase 7 and drives a different value in every other phase, so a capture one edge early or late returns the wrong byte. A request raised only in the middle of a cycle checks that nothing starts outside phase 0. A request held high across several cycles checks that the idle cycle appears between two operations. A read followed by its phase 0 checks that the shared byte is not driven again before phase 1.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    typedef enum logic [2:0] {
        PH0_HOLD     = 3'd0,
        PH1_AS_RISE  = 3'd1,
        PH2_AS_HIGH  = 3'd2,
        PH3_ALO_HOLD = 3'd3,
        PH4_E_RISE   = 3'd4,
        PH5_DATA     = 3'd5,
        PH6_DATA     = 3'd6,
        PH7_SAMPLE   = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        CY_IDLE  = 2'd0,
        CY_READ  = 2'd1,
        CY_WRITE = 2'd2
    } cyc_e;

endpackage

// File: rtl/mxbus_phase.sv
module mxbus_phase
    import mxbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e ph,
    output logic   e_clk,
    output logic   as_strobe
);

    phase_e ph_q;
    phase_e ph_nxt;
    logic   e_q;
    logic   as_q;

    always_comb begin
        ph_nxt = ph_q;
        unique case (ph_q)
            PH0_HOLD:     ph_nxt = PH1_AS_RISE;
            PH1_AS_RISE:  ph_nxt = PH2_AS_HIGH;
            PH2_AS_HIGH:  ph_nxt = PH3_ALO_HOLD;
            PH3_ALO_HOLD: ph_nxt = PH4_E_RISE;
            PH4_E_RISE:   ph_nxt = PH5_DATA;
            PH5_DATA:     ph_nxt = PH6_DATA;
            PH6_DATA:     ph_nxt = PH7_SAMPLE;
            PH7_SAMPLE:   ph_nxt = PH0_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH0_HOLD;
            e_q  <= 1'b0;
            as_q <= 1'b0;
        end else begin
            ph_q <= ph_nxt;
            e_q  <= (ph_nxt == PH4_E_RISE) || (ph_nxt == PH5_DATA) ||
                    (ph_nxt == PH6_DATA)   || (ph_nxt == PH7_SAMPLE);
            as_q <= (ph_nxt == PH1_AS_RISE) || (ph_nxt == PH2_AS_HIGH);
        end
    end

    assign ph        = ph_q;
    assign e_clk     = e_q;
    assign as_strobe = as_q;

    AST_AS_IN_E_LOW: assert property (@(posedge clk) disable iff (rst)
        as_strobe |-> !e_clk); // R3

    AST_E_RISES_AFTER_AS: assert property (@(posedge clk) disable iff (rst)
        $fell(as_strobe) |=> $rose(e_clk)); // R3

endmodule

// File: rtl/mxbus_cycle.sv
module mxbus_cycle
    import mxbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e ph,
    input  logic   req,
    input  logic   req_we,
    output cyc_e   cyc,
    output logic   accept,
    output logic   ack
);

    cyc_e cyc_q;
    cyc_e cyc_nxt;
    logic ack_q;
    logic take;

    assign take = (ph == PH0_HOLD) && req && !ack_q;

    always_comb begin
        cyc_nxt = cyc_q;
        unique case (cyc_q)
            CY_IDLE: begin
                if (take) begin
                    cyc_nxt = req_we ? CY_WRITE : CY_READ;
                end
            end
            CY_READ, CY_WRITE: begin
                if (ph == PH0_HOLD) begin
                    cyc_nxt = CY_IDLE;
                end
            end
            default: cyc_nxt = CY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= CY_IDLE;
            ack_q <= 1'b0;
        end else begin
            cyc_q <= cyc_nxt;
            ack_q <= (ph == PH7_SAMPLE) && (cyc_q != CY_IDLE);
        end
    end

    assign cyc    = cyc_q;
    assign accept = take;
    assign ack    = ack_q;

    AST_ACK_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R8

    AST_ACK_IN_PHASE0: assert property (@(posedge clk) disable iff (rst)
        ack |-> (ph == PH0_HOLD)); // R8

endmodule

// File: rtl/mxbus_datapath.sv
module mxbus_datapath
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            ph,
    input  cyc_e              cyc,
    input  logic              accept,
    input  logic              as_strobe,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic [HI_W-1:0]   ahi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              rw,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rw_q;
    logic              drive_addr;
    logic              oe_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rw_q    <= 1'b1;
        end else begin
            if (ph == PH0_HOLD) begin
                rw_q <= !(accept && req_we);
                if (accept) begin
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                end
            end
            if ((ph == PH7_SAMPLE) && (cyc == CY_READ)) begin
                rdata_q <= ad_in;
            end
        end
    end

    always_comb begin
        drive_addr = 1'b0;
        oe_c       = 1'b0;
        unique case (ph)
            PH0_HOLD: begin
                oe_c = (cyc == CY_WRITE);
            end
            PH1_AS_RISE, PH2_AS_HIGH, PH3_ALO_HOLD: begin
                drive_addr = 1'b1;
                oe_c       = (cyc != CY_IDLE);
            end
            PH4_E_RISE: begin
                drive_addr = 1'b1;
                oe_c       = (cyc == CY_WRITE);
            end
            PH5_DATA, PH6_DATA, PH7_SAMPLE: begin
                oe_c = (cyc == CY_WRITE);
            end
        endcase
    end

    assign ahi    = addr_q[ADDR_W-1:DATA_W];
    assign ad_out = drive_addr ? addr_q[DATA_W-1:0] : wdata_q;
    assign ad_oe  = oe_c;
    assign rw     = rw_q;
    assign rdata  = rdata_q;

    AST_ALO_HELD_PAST_AS: assert property (@(posedge clk) disable iff (rst)
        ($fell(as_strobe) && (cyc != CY_IDLE)) |-> ($stable(ad_out) && ad_oe)); // R5

endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
    import mxbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_e,
    output logic              bus_as,
    output logic              bus_rw,
    output logic [HI_W-1:0]   bus_ahi,
    output logic [DATA_W-1:0] bus_ad_out,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic              bus_ad_oe
);

    phase_e ph;
    cyc_e   cyc;
    logic   accept;

    mxbus_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .e_clk     (bus_e),
        .as_strobe (bus_as)
    );

    mxbus_cycle u_cycle (
        .clk    (clk),
        .rst    (rst),
        .ph     (ph),
        .req    (req),
        .req_we (req_we),
        .cyc    (cyc),
        .accept (accept),
        .ack    (ack)
    );

    mxbus_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_datapath (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .cyc       (cyc),
        .accept    (accept),
        .as_strobe (bus_as),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ad_in     (bus_ad_in),
        .ahi       (bus_ahi),
        .ad_out    (bus_ad_out),
        .ad_oe     (bus_ad_oe),
        .rw        (bus_rw),
        .rdata     (rd_data)
    );

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ack && bus_rw) |-> !bus_ad_oe); // R7

endmodule

// File: tb/mxbus_seq_bench.sv
module mxbus_seq_bench;

    typedef struct {
        logic       we;
        logic [7:0] rd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic        req_we;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        ack;
    logic [7:0]  rd_data;
    logic        bus_e;
    logic        bus_as;
    logic        bus_rw;
    logic [7:0]  bus_ahi;
    logic [7:0]  bus_ad_out;
    logic [7:0]  bus_ad_in;
    logic        bus_ad_oe;

    int unsigned bcnt;
    int          checks = 0;
    int          errors = 0;
    exp_t        sbq[$];
    exp_t        got;

    always #2.5 clk = ~clk;

    mxbus_seq u_mxbus_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ack        (ack),
        .rd_data    (rd_data),
        .bus_e      (bus_e),
        .bus_as     (bus_as),
        .bus_rw     (bus_rw),
        .bus_ahi    (bus_ahi),
        .bus_ad_out (bus_ad_out),
        .bus_ad_in  (bus_ad_in),
        .bus_ad_oe  (bus_ad_oe)
    );

    always @(posedge clk) begin
        if (rst) bcnt <= 0;
        else     bcnt <= bcnt + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every ack pops one expected item (R8, R7)
    always @(negedge clk) begin
        if (!rst && ack) begin
            checks++;
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL R8 ack with nothing outstanding actual=1 expected=0");
            end else begin
                got = sbq.pop_front();
                if (!got.we && rd_data !== got.rd) begin
                    errors++;
                    $display("FAIL R7 read data actual=%0h expected=%0h", rd_data, got.rd);
                end
            end
        end
    end

    task automatic align_p0();
        @(negedge clk);
        while (bcnt[2:0] != 3'd0 || ack) @(negedge clk);
    endtask

    task automatic do_op(input logic we, input logic [15:0] a,
                         input logic [7:0] wd, input logic [7:0] rd);
        align_p0();
        req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        sbq.push_back('{we, rd});
        bus_ad_in = 8'hEE;
        for (int p = 1; p <= 8; p++) begin
            @(negedge clk);
            if (p == 1) begin
                req = 1'b0; req_we = ~we; req_addr = ~a; req_wdata = ~wd;
            end
            chk("R2 E level", bus_e, (p >= 4 && p <= 7));
            chk("R3 AS level", bus_as, (p == 1 || p == 2));
            chk("R5 high address", bus_ahi, a[15:8]);
            chk("R6 rw line", bus_rw, !we);
            if (p <= 3) begin
                chk("R5 low address oe", bus_ad_oe, 1'b1);
                chk("R5 low address", bus_ad_out, a[7:0]);
            end else if (p == 4) begin
                chk("R7 R6 oe phase4", bus_ad_oe, we);
                if (we) chk("R5 low address held", bus_ad_out, a[7:0]);
            end else begin
                chk("R6 R7 oe data phase", bus_ad_oe, we);
                if (we) chk("R6 write data", bus_ad_out, wd);
            end
            if (p == 8) chk("R8 ack in phase 0", ack, 1'b1);
            else        chk("R8 no early ack", ack, 1'b0);
            bus_ad_in = (p == 7) ? rd : (8'hEE ^ 8'(p));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
        bus_ad_in = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 reset E", bus_e, 1'b0);
        chk("R1 reset AS", bus_as, 1'b0);
        chk("R1 reset rw", bus_rw, 1'b1);
        chk("R1 reset oe", bus_ad_oe, 1'b0);
        chk("R1 reset ack", ack, 1'b0);
        rst = 1'b0;

        // Idle running: E and AS pattern, no drive, rw read (R2, R3, R4)
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            chk("R2 idle E", bus_e, bcnt[2]);
            chk("R3 idle AS", bus_as, (bcnt[2:0] == 3'd1 || bcnt[2:0] == 3'd2));
            chk("R4 idle rw", bus_rw, 1'b1);
            chk("R4 idle oe", bus_ad_oe, 1'b0);
        end

        do_op(1'b1, 16'h12A5, 8'h3C, 8'h00);
        do_op(1'b0, 16'hFE01, 8'h00, 8'hC3);
        do_op(1'b0, 16'h7F80, 8'h00, 8'h00);
        do_op(1'b1, 16'h0080, 8'hFF, 8'h00);

        // R4: request high only mid-cycle is not taken
        align_p0();
        for (int p = 1; p <= 16; p++) begin
            @(negedge clk);
            if (p == 3) begin req = 1'b1; req_we = 1'b1; req_addr = 16'hBEEF; end
            if (p == 7) req = 1'b0;
            chk("R4 mid-cycle req ignored rw", bus_rw, 1'b1);
            chk("R4 mid-cycle req ignored oe", bus_ad_oe, 1'b0);
            chk("R4 mid-cycle req no ack", ack, 1'b0);
        end

        // R9: held request gives op, idle, op
        align_p0();
        req = 1'b1; req_we = 1'b1; req_addr = 16'hA55A; req_wdata = 8'h69;
        sbq.push_back('{1'b1, 8'h00});
        sbq.push_back('{1'b1, 8'h00});
        repeat (8) @(negedge clk);
        chk("R9 first ack", ack, 1'b1);
        for (int p = 1; p <= 8; p++) begin
            @(negedge clk);
            if (p <= 7) chk("R9 idle cycle after ack rw", bus_rw, 1'b1);
            else        chk("R9 no ack after idle", ack, 1'b0);
        end
        @(negedge clk);
        chk("R9 second op rw", bus_rw, 1'b0);
        chk("R9 second op address", bus_ahi, 8'hA5);
        req = 1'b0;
        repeat (7) @(negedge clk);
        chk("R9 second ack", ack, 1'b1);

        repeat (20) @(negedge clk);
        chk("R8 all acks seen", sbq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule